// File: doc/BRIEF.md
# Receive Line Break and Error Status Monitor

This block sits beside a serial receiver and watches the receive line, which is sampled on a strobe that fires sixteen times per bit. It measures how long the line stays low without interruption and compares that time with two limits. Both limits are worked out from the frame format currently programmed: the data length, whether a parity bit is present, and whether one or two stop bits are used. A low period longer than one frame is reported as a short break. A low period longer than two frames plus three bits is reported as a long break.

The block also takes single-cycle overrun, parity and framing error pulses from the receiver core. It keeps all five conditions as sticky status bits. Software clears selected bits with a write-one-to-clear strobe and mask. A single interrupt request is raised whenever the enable input is set and at least one status bit is set.

Top module: `rx_break_status`

## Requirements
- R1: After reset, all five status bits and the interrupt request are 0.
- R2: The frame length M, in bits, is one start bit plus the data bits, plus one when `parityOn` is 1, plus the stop bits. Status bit 0 (short break) sets after the line has been sampled low on more than 16·M consecutive `tick16` strobes. It does not set after exactly 16·(M+1)−1 such strobes.
- R3: Status bit 1 (long break) sets once more than 16·(2M+3) consecutive low strobes have been seen, that is, after 16·(2M+4) strobes and not after one strobe fewer. Whenever the long break bit sets, the short break bit is set in the same cycle.
- R4: The data bit count is `dataLen` + 5. A `twoStop` value of 1 means two stop bits and 0 means one. Both break thresholds follow these inputs.
- R5: A strobe that samples the line high resets the low-time measurement, so low runs separated by a high sample do not add together.
- R6: Each break bit sets at most once per low period. If a break bit is cleared while the line is still low, it does not set again until the line has been sampled high and a new low period passes the threshold.
- R7: A one-cycle pulse on `ovrErr`, `parErr` or `frmErr` sets status bit 2, 3 or 4 respectively, and that bit stays set.
- R8: A cycle with `clrStrobe` high clears exactly the status bits whose `clrMask` bit is 1. If a bit is set and cleared in the same cycle, the set wins.
- R9: `irq` is 1 exactly when `irqEnable` is 1 and at least one status bit is 1.
- R10: Cycles without `tick16` do not advance the low-time measurement, whatever level `rxLine` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversample strobe, sixteen per bit time |
| rxLine | input | 1 | Synchronised receive line level |
| dataLen | input | 2 | Data bits minus five |
| parityOn | input | 1 | Frame carries a parity bit |
| twoStop | input | 1 | Frame carries two stop bits |
| ovrErr | input | 1 | Overrun pulse from the receiver core |
| parErr | input | 1 | Parity error pulse from the receiver core |
| frmErr | input | 1 | Framing error pulse from the receiver core |
| irqEnable | input | 1 | Receive status interrupt enable |
| clrStrobe | input | 1 | Write-one-to-clear strobe |
| clrMask | input | 5 | Status bits to clear |
| status | output | 5 | Sticky flags: 0 short break, 1 long break, 2 overrun, 3 parity, 4 framing |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: sixteen strobes per bit, a minimum data length of five bits and a two-bit length field. With these values, frame lengths from 7 to 12 bits can be reached, and the longest break threshold is 448 strobes, which fits easily within the run. The vector table covers 7-bit and 8-bit data with parity on and off, plus one two-stop format. For each format it places a low run one strobe below and exactly at the short and long limits. Directed tests cover split low runs, clearing a flag during a break, stalled strobes, and the case where a set and a clear land in the same cycle.

// File: rtl/rx_break_pkg.sv
package rx_break_pkg;

  localparam int STAT_W   = 5;
  localparam int ST_SHORT = 0;
  localparam int ST_LONG  = 1;
  localparam int ST_OVR   = 2;
  localparam int ST_PAR   = 3;
  localparam int ST_FRM   = 4;

  // strobes from control to the low-time datapath
  typedef struct packed {
    logic cntClr;
    logic cntStep;
  } cntStrb_t;

  typedef enum logic [1:0] {
    BRK_ARMED     = 2'd0,
    BRK_SHORT_HIT = 2'd1,
    BRK_LONG_HIT  = 2'd2
  } brkState_t;

endpackage

// File: rtl/rx_break_datapath.sv
module rx_break_datapath
  import rx_break_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MIN_DATA = 5,
  parameter int LEN_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrb_t         strb,
  input  logic [LEN_W-1:0] dataLen,
  input  logic             parityOn,
  input  logic             twoStop,
  output logic             overShort,
  output logic             overLong
);

  localparam int SUB_W   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int MAX_M   = 1 + MIN_DATA + (2 ** LEN_W - 1) + 1 + 2;
  localparam int CNT_W   = $clog2(2 * MAX_M + 5);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};
  localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(OVS - 1);

  logic [SUB_W-1:0] subCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] frameLen;
  logic [CNT_W-1:0] shortLim;
  logic [CNT_W-1:0] longLim;

  // frame length in bits: start + data + parity + stop
  always_comb begin
    frameLen = CNT_W'(1 + MIN_DATA) + CNT_W'(dataLen) + CNT_W'(parityOn)
             + (twoStop ? CNT_W'(2) : CNT_W'(1));
    shortLim = frameLen;
    longLim  = CNT_W'(frameLen << 1) + CNT_W'(3);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.cntClr) begin
      subCnt <= '0;
      bitCnt <= '0;
    end else if (strb.cntStep) begin
      if (subCnt == SUB_TOP) begin
        subCnt <= '0;
        if (bitCnt != CNT_SAT) bitCnt <= bitCnt + CNT_W'(1);
      end else begin
        subCnt <= subCnt + SUB_W'(1);
      end
    end
  end

  assign overShort = (bitCnt > shortLim);
  assign overLong  = (bitCnt > longLim);

  // R5: a high sample leaves the measurement at zero
  a_r5_high_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> (bitCnt == '0 && subCnt == '0));

  // R10: without a strobe the measurement holds
  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cntClr || strb.cntStep) |=> $stable(bitCnt) && $stable(subCnt));

endmodule

// File: rtl/rx_break_control.sv
module rx_break_control
  import rx_break_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxLine,
  input  logic              overShort,
  input  logic              overLong,
  input  logic              ovrErr,
  input  logic              parErr,
  input  logic              frmErr,
  input  logic              clrStrobe,
  input  logic [STAT_W-1:0] clrMask,
  output cntStrb_t          strb,
  output logic [STAT_W-1:0] status
);

  brkState_t         state, stateNext;
  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] clrVec;

  always_comb begin
    strb.cntClr  = tick16 && rxLine;
    strb.cntStep = tick16 && !rxLine;
  end

  // break tracking: one report per class per low period
  always_comb begin
    stateNext = state;
    setVec    = '0;
    if (strb.cntClr) begin
      stateNext = BRK_ARMED;
    end else begin
      unique case (state)
        BRK_ARMED: begin
          if (overLong) begin
            setVec[ST_LONG]  = 1'b1;
            setVec[ST_SHORT] = 1'b1;
            stateNext        = BRK_LONG_HIT;
          end else if (overShort) begin
            setVec[ST_SHORT] = 1'b1;
            stateNext        = BRK_SHORT_HIT;
          end
        end
        BRK_SHORT_HIT: begin
          if (overLong) begin
            setVec[ST_LONG]  = 1'b1;
            setVec[ST_SHORT] = 1'b1;
            stateNext        = BRK_LONG_HIT;
          end
        end
        BRK_LONG_HIT: stateNext = BRK_LONG_HIT;
        default:      stateNext = BRK_ARMED;
      endcase
    end
    setVec[ST_OVR] = ovrErr;
    setVec[ST_PAR] = parErr;
    setVec[ST_FRM] = frmErr;
    clrVec = clrStrobe ? clrMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= BRK_ARMED;
      status <= '0;
    end else begin
      state  <= stateNext;
      status <= (status & ~clrVec) | setVec;
    end
  end

  // R3: long break never appears without short break
  a_r3_long_with_short: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[ST_LONG]) |-> status[ST_SHORT]);

  // R2: short break only after the datapath reports the limit passed
  a_r2_short_after_limit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[ST_SHORT]) |-> $past(overShort));

  // R7: an error pulse leaves its flag set
  a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    ovrErr |=> status[ST_OVR]);

  // R8: a set flag with no clear request stays set
  a_r8_framing_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (status[ST_FRM] && !(clrStrobe && clrMask[ST_FRM])) |=> status[ST_FRM]);

endmodule

// File: rtl/rx_break_status.sv
module rx_break_status
  import rx_break_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MIN_DATA = 5,
  parameter int LEN_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxLine,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              parityOn,
  input  logic              twoStop,
  input  logic              ovrErr,
  input  logic              parErr,
  input  logic              frmErr,
  input  logic              irqEnable,
  input  logic              clrStrobe,
  input  logic [STAT_W-1:0] clrMask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  cntStrb_t strb;
  logic     overShort;
  logic     overLong;

  rx_break_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .tick16    (tick16),
    .rxLine    (rxLine),
    .overShort (overShort),
    .overLong  (overLong),
    .ovrErr    (ovrErr),
    .parErr    (parErr),
    .frmErr    (frmErr),
    .clrStrobe (clrStrobe),
    .clrMask   (clrMask),
    .strb      (strb),
    .status    (status)
  );

  rx_break_datapath #(
    .OVS      (OVS),
    .MIN_DATA (MIN_DATA),
    .LEN_W    (LEN_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dataLen   (dataLen),
    .parityOn  (parityOn),
    .twoStop   (twoStop),
    .overShort (overShort),
    .overLong  (overLong)
  );

  assign irq = irqEnable && (|status);

  // R9: with the enable low the request stays low
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irq);

endmodule

// File: tb/rx_break_status_bench.sv
`timescale 1ns/1ps
module rx_break_status_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick16;
  logic       rxLine;
  logic [1:0] dataLen;
  logic       parityOn;
  logic       twoStop;
  logic       ovrErr, parErr, frmErr;
  logic       irqEnable;
  logic       clrStrobe;
  logic [4:0] clrMask;
  logic [4:0] status;
  logic       irq;

  int nRun  = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  rx_break_status u_rx_break_status (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .dataLen(dataLen), .parityOn(parityOn), .twoStop(twoStop),
    .ovrErr(ovrErr), .parErr(parErr), .frmErr(frmErr),
    .irqEnable(irqEnable), .clrStrobe(clrStrobe), .clrMask(clrMask),
    .status(status), .irq(irq)
  );

  // {dataLen[1:0], parity, twoStop, kind[1:0], expShort, expLong}
  // kind 0: just below short, 1: at short, 2: just below long, 3: at long
  localparam logic [7:0] VEC [20] = '{
    8'b10_0_0_00_0_0, 8'b10_0_0_01_1_0, 8'b10_0_0_10_1_0, 8'b10_0_0_11_1_1,
    8'b10_1_0_00_0_0, 8'b10_1_0_01_1_0, 8'b10_1_0_10_1_0, 8'b10_1_0_11_1_1,
    8'b11_0_0_00_0_0, 8'b11_0_0_01_1_0, 8'b11_0_0_10_1_0, 8'b11_0_0_11_1_1,
    8'b11_1_0_00_0_0, 8'b11_1_0_01_1_0, 8'b11_1_0_10_1_0, 8'b11_1_0_11_1_1,
    8'b11_1_1_00_0_0, 8'b11_1_1_01_1_0, 8'b11_1_1_10_1_0, 8'b11_1_1_11_1_1
  };

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic oneTick(input logic lvl);
    rxLine = lvl;
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
    @(negedge clk);
  endtask

  task automatic lowRun(input int n);
    for (int i = 0; i < n; i++) oneTick(1'b0);
    @(negedge clk);
  endtask

  task automatic clearBits(input logic [4:0] m);
    clrMask   = m;
    clrStrobe = 1'b1;
    @(negedge clk);
    clrStrobe = 1'b0;
    clrMask   = '0;
    @(negedge clk);
  endtask

  function automatic int frameBits(input logic [1:0] dl, input logic p, input logic s2);
    return 1 + (int'(dl) + 5) + int'(p) + (s2 ? 2 : 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; tick16 = 0; rxLine = 1; dataLen = 2'd3; parityOn = 0; twoStop = 0;
    ovrErr = 0; parErr = 0; frmErr = 0; irqEnable = 1; clrStrobe = 0; clrMask = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", status, 0);
    check("R1 irq", irq, 0);

    // R2 R3 R4 threshold table
    foreach (VEC[k]) begin
      automatic logic [7:0] v = VEC[k];
      automatic int m = frameBits(v[7:6], v[5], v[4]);
      automatic int n;
      dataLen = v[7:6]; parityOn = v[5]; twoStop = v[4];
      oneTick(1'b1);
      clearBits(5'h1f);
      case (v[3:2])
        2'd0: n = 16 * (m + 1) - 1;
        2'd1: n = 16 * (m + 1);
        2'd2: n = 16 * (2 * m + 4) - 1;
        default: n = 16 * (2 * m + 4);
      endcase
      lowRun(n);
      check($sformatf("R2 R4 short vec%0d", k), status[0], v[1]);
      check($sformatf("R3 R4 long vec%0d", k), status[1], v[0]);
      check($sformatf("R9 irq vec%0d", k), irq, v[1]);
    end

    // R5 two runs split by one high sample do not add up (8 data, no parity, 1 stop: M=10)
    dataLen = 2'd3; parityOn = 0; twoStop = 0;
    oneTick(1'b1); clearBits(5'h1f);
    lowRun(16 * 11 - 1);
    oneTick(1'b1);
    lowRun(16 * 11 - 1);
    check("R5 split run no short", status[0], 0);

    // R6 clearing during a break does not re-report in the same low period
    lowRun(1);
    check("R6 short set", status[0], 1);
    clearBits(5'h01);
    lowRun(32);
    check("R6 no second report", status[0], 0);
    oneTick(1'b1);
    lowRun(16 * 11);
    check("R6 new period reports", status[0], 1);

    // R10 stalled strobes hold the count
    oneTick(1'b1); clearBits(5'h1f);
    lowRun(16 * 11 - 1);
    rxLine = 1'b0;
    repeat (400) @(negedge clk);
    check("R10 no advance without tick", status[0], 0);
    lowRun(1);
    check("R10 count resumed", status[0], 1);
    oneTick(1'b1); clearBits(5'h1f);

    // R7 error pulses
    ovrErr = 1; @(negedge clk); ovrErr = 0;
    parErr = 1; @(negedge clk); parErr = 0;
    frmErr = 1; @(negedge clk); frmErr = 0;
    repeat (3) @(negedge clk);
    check("R7 errors sticky", status, 5'b11100);

    // R8 partial clear, then set wins over clear
    clearBits(5'b01000);
    check("R8 partial clear", status, 5'b10100);
    ovrErr = 1; clrStrobe = 1; clrMask = 5'b00100;
    @(negedge clk);
    ovrErr = 0; clrStrobe = 0; clrMask = '0;
    @(negedge clk);
    check("R8 set wins", status, 5'b10100);

    // R9 enable gating
    irqEnable = 0; @(negedge clk);
    check("R9 masked", irq, 0);
    irqEnable = 1; @(negedge clk);
    check("R9 enabled", irq, 1);
    clearBits(5'h1f);
    check("R9 none pending", irq, 0);
    check("R8 all cleared", status, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule